// File: doc/BRIEF.md
# Byte-Wide EEPROM Page Write Controller

This block is a clocked, synthesizable model of the write engine inside a byte-wide electrically erasable memory. Four asynchronous active-low strobes arrive from the pins: chip select, output enable, write enable and a protect/reset line. They pass through a two-stage synchronizer and a pulse filter, so short noise on the control lines never counts as a write. A write begins when chip select and write enable are both low. The address is taken when the second of the two goes low. The data is taken when the first of the two goes high. Each accepted byte goes into a page buffer of 32 bytes.

Loading ends on its own. A byte load is accepted only if it starts within a short window after the start of the previous load. Once no load has been in progress for a longer idle time after the last data input, a timed program phase copies every loaded byte of the page into the memory array. During the whole write cycle an open-drain busy output is pulled low. A read during that time returns the complement of bit 7 of the most recent loaded byte, which lets software poll for completion. Pulling the protect line low blocks reads and writes and abandons a program phase in progress.

Every delay is a counter derived from the clock frequency in MHz. The default array has 2048 bytes (`ADDR_W` = 11). Setting `ADDR_W` to 13 gives the full 8192-byte part.

Top module: `pgwr_eeprom`

## Requirements
- R1: After `rstN` is released, `rdyBusyOe` is 0 and `dataOe` is 0 until the strobes request a read or a write.
- R2: `dataOe` is 1 only while `ceN`=0, `oeN`=0, `weN`=1 and `resN`=1. When idle, `dataOut` then carries the stored byte at `addr`. In every other case `dataOe` is 0.
- R3: A write strobe is the interval in which `ceN` and `weN` are both low. The address is taken at its start and the data at its end. A single loaded byte is found at that address once the program phase has finished.
- R4: Address bits [ADDR_W-1:5] of the first accepted load select the page for the whole cycle, and bits [4:0] of each load select the byte. The page bits of later loads are ignored. Bytes that are not loaded keep their old contents. A byte loaded twice keeps the later value.
- R5: A load that starts more than `BLC_US` microseconds after the start of the previously accepted load is ignored.
- R6: The program phase begins once `BL_US` microseconds have passed with no byte in progress since the last data input.
- R7: The program phase lasts `PROG_US` microseconds. The array is updated during its last 32 cycles, and the busy output is released at its end.
- R8: `rdyBusyOe` (1 = pull the ready/busy line low) rises right after the first accepted write strobe and stays 1 until programming ends.
- R9: While `rdyBusyOe` is 1, a read returns on bit 7 of `dataOut` the complement of bit 7 of the last loaded byte.
- R10: While `resN` is low, reads are blocked (`dataOe`=0) and write strobes are ignored. A program phase in progress is abandoned: busy drops, and the array is unchanged if the abort comes before the final 32 program cycles.
- R11: A write strobe lasting `GLITCH_NS` nanoseconds or less is ignored: busy stays 0 and nothing is stored.
- R12: Write strobes that begin during the program phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, `CLK_MHZ` MHz |
| rstN | input | 1 | Active-low asynchronous reset of the model |
| ceN | input | 1 | Chip select, active low, asynchronous |
| oeN | input | 1 | Output enable, active low, asynchronous |
| weN | input | 1 | Write enable, active low, asynchronous |
| resN | input | 1 | Protect/reset line, low blocks access and aborts programming |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data, or polling status while busy |
| dataOe | output | 1 | Output driver enable for `dataOut` |
| rdyBusyOe | output | 1 | 1 pulls the open-drain ready/busy line low |

## Verification
The bound checker watches the relations that hold on every cycle between the filtered strobes and the outputs. These are: no output drive without a valid read request, no read while the protect line is low, an immediate drop of busy when a protect abort happens during a write cycle, and busy only ever rising after an active write strobe. The bench scenarios cover what depends on timing windows and on stored contents. Those include page assembly with repeated and foreign-page loads, the late-load cutoff, the idle and program durations, polling on bit 7, rejected glitches, strobes ignored during programming, and an array left untouched after an abort.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  localparam int OFF_W      = 5;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int DATA_W     = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } wrState_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic             latchAddr;
    logic             latchPage;
    logic             loadByte;
    logic             clearPage;
    logic             commitEn;
    logic [OFF_W-1:0] commitIdx;
    logic             readEn;
    logic             busy;
  } ctrlStrobe_t;
endpackage

// File: rtl/pgwr_sync.sv
module pgwr_sync #(
  parameter int          N        = 4,
  parameter int          FILT_CYC = 5,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] rawIn,
  output logic [N-1:0] filtOut
);
  localparam int CW = $clog2(FILT_CYC + 1);

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic          s1, s2, f;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s1  <= RST_VAL[i];
        s2  <= RST_VAL[i];
        f   <= RST_VAL[i];
        cnt <= '0;
      end else begin
        s1 <= rawIn[i];
        s2 <= s1;
        if (s2 == f) begin
          cnt <= '0;
        end else if (cnt == CW'(FILT_CYC - 1)) begin
          f   <= s2;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign filtOut[i] = f;
  end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int BLC_CYC  = 6000,
  parameter int BL_CYC   = 20000,
  parameter int PROG_CYC = 2000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceF,
  input  logic        oeF,
  input  logic        weF,
  input  logic        resF,
  output ctrlStrobe_t strobe
);
  localparam int WCW          = $clog2(BLC_CYC + 1);
  localparam int ICW          = $clog2(BL_CYC + 1);
  localparam int PCW          = $clog2(PROG_CYC + 1);
  localparam int COMMIT_START = PROG_CYC - PAGE_BYTES;

  wrState_t       state;
  logic           wrAct, wrActQ, startEdge, endEdge;
  logic           inByte, winOpen, hasData;
  logic [WCW-1:0] winCnt;
  logic [ICW-1:0] idleCnt;
  logic [PCW-1:0] progCnt;
  logic           idleDone, progDone, acceptStart, loadNow;

  assign wrAct     = !ceF && !weF && resF;
  assign startEdge = wrAct && !wrActQ;
  assign endEdge   = !wrAct && wrActQ && resF;

  always_comb begin
    idleDone    = (state == ST_LOAD) && resF && hasData && !inByte &&
                  (idleCnt == ICW'(BL_CYC - 1));
    progDone    = (state == ST_PROG) && resF && (progCnt == PCW'(PROG_CYC - 1));
    acceptStart = startEdge &&
                  ((state == ST_IDLE) || ((state == ST_LOAD) && winOpen && !idleDone));
    loadNow     = (state == ST_LOAD) && endEdge && inByte;

    strobe.latchAddr = acceptStart;
    strobe.latchPage = acceptStart && (state == ST_IDLE);
    strobe.loadByte  = loadNow;
    strobe.clearPage = ((state != ST_IDLE) && !resF) || progDone;
    strobe.commitEn  = (state == ST_PROG) && resF && (progCnt >= PCW'(COMMIT_START));
    strobe.commitIdx = OFF_W'(progCnt - PCW'(COMMIT_START));
    strobe.readEn    = !ceF && !oeF && weF && resF;
    strobe.busy      = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wrActQ  <= 1'b0;
      inByte  <= 1'b0;
      winOpen <= 1'b0;
      hasData <= 1'b0;
      winCnt  <= '0;
      idleCnt <= '0;
      progCnt <= '0;
    end else begin
      wrActQ <= wrAct;
      case (state)
        ST_IDLE: begin
          if (acceptStart) begin
            state   <= ST_LOAD;
            inByte  <= 1'b1;
            winOpen <= 1'b1;
            winCnt  <= '0;
            idleCnt <= '0;
            hasData <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (!resF) begin
            state  <= ST_IDLE;
            inByte <= 1'b0;
          end else begin
            if (winOpen) begin
              if (winCnt == WCW'(BLC_CYC - 1)) winOpen <= 1'b0;
              else                             winCnt  <= winCnt + 1'b1;
            end
            if (loadNow) begin
              inByte  <= 1'b0;
              hasData <= 1'b1;
              idleCnt <= '0;
            end else if (idleDone) begin
              state   <= ST_PROG;
              progCnt <= '0;
            end else if (!inByte && hasData) begin
              idleCnt <= idleCnt + 1'b1;
            end
            if (acceptStart) begin
              inByte  <= 1'b1;
              winOpen <= 1'b1;
              winCnt  <= '0;
              idleCnt <= '0;
            end
          end
        end
        ST_PROG: begin
          if (!resF || progDone) state   <= ST_IDLE;
          else                   progCnt <= progCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgwr_dp.sv
module pgwr_dp
  import pgwr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PG_W-1:0]       pageQ;
  logic [OFF_W-1:0]      offQ;
  logic [PAGE_BYTES-1:0] validQ;
  logic [DATA_W-1:0]     lastData;
  logic [DATA_W-1:0]     pageBuf [PAGE_BYTES];
  logic [DATA_W-1:0]     mem     [DEPTH];
  logic [DATA_W-1:0]     rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ    <= '0;
      offQ     <= '0;
      validQ   <= '0;
      lastData <= '0;
      dataOut  <= '0;
      dataOe   <= 1'b0;
    end else begin
      if (strobe.latchPage) pageQ <= addrIn[ADDR_W-1:OFF_W];
      if (strobe.latchAddr) offQ  <= addrIn[OFF_W-1:0];
      if (strobe.clearPage)     validQ       <= '0;
      else if (strobe.loadByte) validQ[offQ] <= 1'b1;
      if (strobe.loadByte) lastData <= dataIn;
      dataOe <= strobe.readEn;
      if (!strobe.readEn)   dataOut <= '0;
      else if (strobe.busy) dataOut <= {~lastData[DATA_W-1], rdQ[DATA_W-2:0]};
      else                  dataOut <= rdQ;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.loadByte) pageBuf[offQ] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (strobe.commitEn && validQ[strobe.commitIdx])
      mem[{pageQ, strobe.commitIdx}] <= pageBuf[strobe.commitIdx];
    rdQ <= mem[addrIn];
  end
endmodule

// File: rtl/pgwr_eeprom.sv
module pgwr_eeprom
  import pgwr_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int CLK_MHZ   = 200,
  parameter int BLC_US    = 30,
  parameter int BL_US     = 100,
  parameter int PROG_US   = 10000,
  parameter int GLITCH_NS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              resN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output logic              rdyBusyOe
);
  localparam int BLC_CYC    = BLC_US * CLK_MHZ;
  localparam int BL_CYC     = BL_US * CLK_MHZ;
  localparam int PROG_CYC   = PROG_US * CLK_MHZ;
  localparam int GLITCH_CYC = (GLITCH_NS * CLK_MHZ + 999) / 1000;
  localparam int FILT_CYC   = GLITCH_CYC + 1;

  logic [3:0]  filt;
  logic        ceF, oeF, weF, resF;
  ctrlStrobe_t strobe;

  pgwr_sync #(.N(4), .FILT_CYC(FILT_CYC), .RST_VAL(4'b0111)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   ({resN, weN, oeN, ceN}),
    .filtOut (filt)
  );

  assign ceF  = filt[0];
  assign oeF  = filt[1];
  assign weF  = filt[2];
  assign resF = filt[3];

  pgwr_ctrl #(.BLC_CYC(BLC_CYC), .BL_CYC(BL_CYC), .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ceF    (ceF),
    .oeF    (oeF),
    .weF    (weF),
    .resF   (resF),
    .strobe (strobe)
  );

  pgwr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .addrIn  (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

  assign rdyBusyOe = strobe.busy;
endmodule

// File: rtl/pgwr_checker.sv
module pgwr_checker (
  input logic clk,
  input logic rstN,
  input logic ceF,
  input logic oeF,
  input logic weF,
  input logic resF,
  input logic dataOe,
  input logic rdyBusyOe
);
  // R2: no output drive unless select, output enable and a high write enable were seen
  a_r2_no_drive_without_read: assert property (@(posedge clk) disable iff (!rstN)
    (ceF || oeF || !weF) |=> !dataOe);

  // R10: protect line low blocks reads
  a_r10_no_read_when_protected: assert property (@(posedge clk) disable iff (!rstN)
    !resF |=> !dataOe);

  // R10: protect line low ends any write cycle at once
  a_r10_abort_drops_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!resF && rdyBusyOe) |=> !rdyBusyOe);

  // R8: busy only starts after an active write strobe
  a_r8_busy_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdyBusyOe) |-> $past(!ceF && !weF && resF));
endmodule

bind pgwr_eeprom pgwr_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ceF       (ceF),
  .oeF       (oeF),
  .weF       (weF),
  .resF      (resF),
  .dataOe    (dataOe),
  .rdyBusyOe (rdyBusyOe)
);

// File: tb/sim_pgwr_eeprom.sv
`timescale 1ns/1ps
module sim_pgwr_eeprom;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rstN, ceN, oeN, weN, resN;
  logic [AW-1:0] addr;
  logic [7:0]    dataIn;
  logic [7:0]    dataOut;
  logic          dataOe, rdyBusyOe;

  int testCount = 0;
  int failCount = 0;

  logic [7:0]    expMem [1 << AW];
  int            nLoads;
  logic [AW-1:0] la [64];
  logic [7:0]    ld [64];

  always #2.5 clk = ~clk;

  pgwr_eeprom #(.ADDR_W(AW), .CLK_MHZ(200), .BLC_US(1), .BL_US(2),
                .PROG_US(4), .GLITCH_NS(20)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .resN(resN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .rdyBusyOe(rdyBusyOe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobeByte(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    tick(12);
    weN = 1'b1; ceN = 1'b1;
    tick(12);
  endtask

  task automatic readByte(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    tick(12);
    d = dataOut; oe = dataOe;
    oeN = 1'b1; ceN = 1'b1;
    tick(10);
  endtask

  task automatic waitReady();
    for (int i = 0; i < 5000 && rdyBusyOe; i++) tick(1);
    tick(4);
  endtask

  // Loads la/ld, waits for completion and updates the model (page from first load)
  task automatic runCycle();
    logic [AW-6:0] pg;
    pg = la[0][AW-1:5];
    for (int i = 0; i < nLoads; i++) strobeByte(la[i], ld[i]);
    waitReady();
    for (int i = 0; i < nLoads; i++) expMem[{pg, la[i][4:0]}] = ld[i];
  endtask

  task automatic checkPage(input logic [AW-6:0] pg, input string req);
    logic [7:0] d; logic oe;
    for (int o = 0; o < 32; o++) begin
      readByte({pg, 5'(o)}, d, oe);
      chk(oe && d == expMem[{pg, 5'(o)}], req, int'(d), int'(expMem[{pg, 5'(o)}]));
    end
  endtask

  initial begin
    tick(190000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [7:0]    d, x;
    logic          oe;
    logic [AW-1:0] a;
    logic [AW-6:0] pg;
    void'($urandom(32'd4711));
    rstN = 1'b0; ceN = 1'b1; oeN = 1'b1; weN = 1'b1; resN = 1'b1;
    addr = '0; dataIn = '0;
    tick(5);
    // R1: reset state
    chk(rdyBusyOe == 1'b0, "R1 busy", int'(rdyBusyOe), 0);
    chk(dataOe == 1'b0, "R1 oe", int'(dataOe), 0);
    rstN = 1'b1;
    tick(20);
    chk(rdyBusyOe == 1'b0 && dataOe == 1'b0, "R1 after release", int'({rdyBusyOe, dataOe}), 0);

    // Single byte: R3, R8, R9, R6, R7
    a = AW'($urandom % (1 << AW)); d = 8'($urandom);
    strobeByte(a, d);
    chk(rdyBusyOe == 1'b1, "R8 busy after strobe", int'(rdyBusyOe), 1);
    readByte(a, x, oe);
    chk(oe && x[7] == ~d[7], "R9 polling bit7", int'(x[7]), int'(~d[7]));
    tick(1128);
    chk(rdyBusyOe == 1'b1, "R6 R7 still busy", int'(rdyBusyOe), 1);
    tick(100);
    chk(rdyBusyOe == 1'b0, "R7 programming ended", int'(rdyBusyOe), 0);
    expMem[a] = d;
    readByte(a, x, oe);
    chk(oe && x == d, "R3 single byte readback", int'(x), int'(d));

    // Pages: full prefill then random partial update with foreign page bits and repeats (R4)
    for (int p = 0; p < 3; p++) begin
      pg = (AW-5)'($urandom);
      nLoads = 32;
      for (int i = 0; i < 32; i++) begin la[i] = {pg, 5'(i)}; ld[i] = 8'($urandom); end
      runCycle();
      checkPage(pg, "R4 full page");
      nLoads = 4 + $urandom % 20;
      for (int i = 0; i < nLoads; i++) begin
        la[i] = (i == 0) ? {pg, 5'($urandom)} : {(AW-5)'($urandom), 5'($urandom)};
        ld[i] = 8'($urandom);
      end
      la[nLoads] = {pg, la[0][4:0]}; ld[nLoads] = ~ld[0];  // repeat of first byte
      nLoads++;
      addr = la[0];
      strobeByte(la[0], ld[0]);
      readByte(la[0], x, oe);
      chk(x[7] == ~ld[0][7], "R9 polling mid load", int'(x[7]), int'(~ld[0][7]));
      for (int i = 1; i < nLoads; i++) strobeByte(la[i], ld[i]);
      waitReady();
      for (int i = 0; i < nLoads; i++) expMem[{pg, la[i][4:0]}] = ld[i];
      checkPage(pg, "R4 partial page");
    end

    // R5: load after window is ignored
    strobeByte({pg, 5'd1}, 8'hA5);
    tick(250);
    strobeByte({pg, 5'd2}, 8'h3C);
    waitReady();
    expMem[{pg, 5'd1}] = 8'hA5;
    readByte({pg, 5'd2}, x, oe);
    chk(x == expMem[{pg, 5'd2}], "R5 late load ignored", int'(x), int'(expMem[{pg, 5'd2}]));
    readByte({pg, 5'd1}, x, oe);
    chk(x == 8'hA5, "R5 first load kept", int'(x), 'hA5);

    // R12: strobe during program ignored
    strobeByte({pg, 5'd3}, 8'h5A);
    tick(500);
    strobeByte({pg, 5'd4}, 8'hC3);
    waitReady();
    expMem[{pg, 5'd3}] = 8'h5A;
    readByte({pg, 5'd4}, x, oe);
    chk(x == expMem[{pg, 5'd4}], "R12 strobe in program ignored", int'(x), int'(expMem[{pg, 5'd4}]));
    readByte({pg, 5'd3}, x, oe);
    chk(x == 8'h5A, "R12 programmed byte", int'(x), 'h5A);

    // R11: 4-cycle (20 ns) strobe is noise
    addr = {pg, 5'd5}; dataIn = ~expMem[{pg, 5'd5}]; ceN = 1'b0; weN = 1'b0;
    tick(4);
    ceN = 1'b1; weN = 1'b1;
    tick(50);
    chk(rdyBusyOe == 1'b0, "R11 glitch no busy", int'(rdyBusyOe), 0);
    readByte({pg, 5'd5}, x, oe);
    chk(x == expMem[{pg, 5'd5}], "R11 glitch no write", int'(x), int'(expMem[{pg, 5'd5}]));

    // R10: abort during program
    strobeByte({pg, 5'd6}, ~expMem[{pg, 5'd6}]);
    tick(600);
    resN = 1'b0;
    tick(20);
    chk(rdyBusyOe == 1'b0, "R10 abort drops busy", int'(rdyBusyOe), 0);
    readByte({pg, 5'd6}, x, oe);
    chk(oe == 1'b0, "R10 read blocked", int'(oe), 0);
    resN = 1'b1;
    tick(20);
    readByte({pg, 5'd6}, x, oe);
    chk(oe && x == expMem[{pg, 5'd6}], "R10 array unchanged", int'(x), int'(expMem[{pg, 5'd6}]));

    // R2: output enable conditions
    addr = {pg, 5'd7}; ceN = 1'b0; oeN = 1'b1;
    tick(12);
    chk(dataOe == 1'b0, "R2 oeN high", int'(dataOe), 0);
    ceN = 1'b1; oeN = 1'b0;
    tick(12);
    chk(dataOe == 1'b0, "R2 ceN high", int'(dataOe), 0);
    oeN = 1'b1;
    tick(12);
    readByte({pg, 5'd7}, x, oe);
    chk(oe && x == expMem[{pg, 5'd7}], "R2 idle read", int'(x), int'(expMem[{pg, 5'd7}]));

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule